// File: doc/BRIEF.md
# Serial Data Lock Detector

This block decides whether a clock-recovery loop can be trusted to follow the incoming data or must be steered onto the local reference clock. Two checks run side by side on the recovered bit stream. A run-length monitor watches for overly long stretches without a level change. A frequency meter counts recovered bits across a window of reference ticks and compares the total with the nominal count, within a tolerance set in parts per million.

The recovered bits arrive as a stream with a valid strobe (`rbit_vld_i`, one pulse per recovered clock cycle). There is no ready signal and no back-pressure: every bit presented with valid high is accepted in that cycle, and cycles with valid low carry no bit. The reference tick, loss-of-signal input and ppm threshold are plain control pins. `lock_o` reports the locked state. `ref_sel_o` tells the loop to track the reference whenever the block is not locked. While unlocked, the block keeps evaluating the data and regains lock on its own once a whole measurement window has been clean.

Top module: `sdata_lock_detect`

## Requirements
- R1: While locked, a run of more than RUN_LIMIT (default 80) consecutive valid bits of equal value drops `lock_o` on the clock edge after the bit that exceeds the limit. A run of exactly RUN_LIMIT bits followed by a change has no effect on `lock_o`.
- R2: The run count restarts at one on every valid bit that differs from the previous valid bit, and saturates at RUN_LIMIT+1 instead of wrapping. An unbroken run of any length therefore keeps the block unlocked.
- R3: A measurement window spans 2^WIN_LOG2 reference ticks and counts the valid bits in it. The nominal count is RATIO·2^WIN_LOG2 (128 by default). If the absolute deviation from nominal exceeds floor(nominal·`ppm_i`/1,000,000), the window fails and drops lock. A deviation equal to that tolerance passes.
- R4: From the unlocked state, lock is declared only at the end of a window that passed the frequency test, with no run-length violation and no loss of signal anywhere in that window.
- R5: `los_i` high drops `lock_o` on the next clock edge and prevents relock for as long as it stays high.
- R6: After reset the block is unlocked. At all times `ref_sel_o` is the inverse of `lock_o`, so the reference is selected in every state except locked.
- R7: Only cycles with `rbit_vld_i` high contribute bits. A window with no valid bits fails the frequency test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rbit_i | input | 1 | Recovered data bit |
| rbit_vld_i | input | 1 | Valid strobe for `rbit_i`, one per recovered clock cycle |
| ref_tick_i | input | 1 | One-cycle pulse per local reference clock period |
| los_i | input | 1 | Loss-of-signal indication |
| ppm_i | input | PPM_W | Allowed frequency deviation in parts per million |
| lock_o | output | 1 | High while locked to data |
| ref_sel_o | output | 1 | High when the loop must track the reference |

## Verification
The bench varies the reference tick period against a steady bit rate. This gives fast, slow and nominal frequencies, each tried at ppm settings just inside, exactly at and just outside the tolerance, so the comparison edge is pinned from both sides. Runs of exactly the limit and one bit beyond it separate the run-length threshold from an off-by-one. A very long flat run checks that the counter holds at its cap and that lock returns once transitions resume. Loss-of-signal pulses and long holds, together with stretches of invalid bits, show which events block relock and that only valid bits are counted.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  typedef enum logic [0:0] {
    LD_HUNT   = 1'b0,
    LD_LOCKED = 1'b1
  } ld_state_e;

  // Allowed count deviation for a nominal count and a ppm threshold.
  function automatic logic [63:0] tol_of(input logic [63:0] nominal,
                                         input logic [63:0] ppm);
    tol_of = (nominal * ppm) / 64'd1_000_000;
  endfunction

endpackage

// File: rtl/lockdet_runlen.sv
module lockdet_runlen #(
  parameter  int unsigned RUN_LIMIT = 80,
  localparam int unsigned CW        = $clog2(RUN_LIMIT + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_i,
  input  logic          bit_vld_i,
  output logic          run_bad_o,
  output logic [CW-1:0] run_len_o
);

  localparam logic [CW-1:0] SAT   = CW'(RUN_LIMIT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RUN_LIMIT);

  logic          prev_q;
  logic          seen_q;
  logic [CW-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
      len_q  <= '0;
    end else if (bit_vld_i) begin
      prev_q <= bit_i;
      seen_q <= 1'b1;
      if (!seen_q || (bit_i != prev_q)) begin
        len_q <= CW'(1);
      end else if (len_q != SAT) begin
        len_q <= len_q + CW'(1);
      end
    end
  end

  assign run_bad_o = (len_q > LIMIT);
  assign run_len_o = len_q;

endmodule

// File: rtl/lockdet_freq.sv
module lockdet_freq
  import lockdet_pkg::*;
#(
  parameter  int unsigned WIN_LOG2  = 4,
  parameter  int unsigned RATIO     = 8,
  parameter  int unsigned PPM_W     = 20,
  localparam int unsigned WIN_TICKS = 1 << WIN_LOG2,
  localparam int unsigned NOMINAL   = RATIO * WIN_TICKS,
  localparam int unsigned CNT_MAX   = 2 * NOMINAL + 1,
  localparam int unsigned CW        = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld_i,
  input  logic             ref_tick_i,
  input  logic [PPM_W-1:0] ppm_i,
  output logic             done_o,
  output logic             ok_o
);

  localparam logic [CW-1:0] NOM_C = CW'(NOMINAL);
  localparam logic [CW-1:0] MAX_C = CW'(CNT_MAX);

  logic [WIN_LOG2-1:0] tick_q;
  logic [CW-1:0]       cnt_q;
  logic [CW-1:0]       cnt_inc;
  logic [CW-1:0]       dev;
  logic [63:0]         tol;
  logic                win_end;

  // Count including the bit of the current cycle, saturating at the cap.
  always_comb begin
    cnt_inc = cnt_q;
    if (bit_vld_i && (cnt_q != MAX_C)) cnt_inc = cnt_q + CW'(1);
  end

  assign dev     = (cnt_inc >= NOM_C) ? (cnt_inc - NOM_C) : (NOM_C - cnt_inc);
  assign tol     = tol_of(64'(NOMINAL), 64'(ppm_i));
  assign win_end = ref_tick_i && (tick_q == {WIN_LOG2{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
      ok_o   <= 1'b0;
    end else begin
      if (ref_tick_i) tick_q <= tick_q + 1'b1;
      if (win_end) begin
        cnt_q  <= '0;
        done_o <= 1'b1;
        ok_o   <= (64'(dev) <= tol);
      end else begin
        cnt_q  <= cnt_inc;
        done_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lockdet_fsm.sv
module lockdet_fsm
  import lockdet_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_bad_i,
  input  logic los_i,
  input  logic win_done_i,
  input  logic win_ok_i,
  output logic locked_o
);

  ld_state_e state_q, state_d;
  logic      taint_q;
  logic      fault;

  assign fault = run_bad_i || los_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LD_HUNT: begin
        if (win_done_i && win_ok_i && !taint_q && !fault) state_d = LD_LOCKED;
      end
      LD_LOCKED: begin
        if (fault || (win_done_i && !win_ok_i)) state_d = LD_HUNT;
      end
      default: state_d = LD_HUNT;
    endcase
  end

  // taint_q remembers any fault seen since the last window close.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_HUNT;
      taint_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (win_done_i)  taint_q <= fault;
      else if (fault)  taint_q <= 1'b1;
    end
  end

  assign locked_o = (state_q == LD_LOCKED);

endmodule

// File: rtl/sdata_lock_detect.sv
module sdata_lock_detect #(
  parameter  int unsigned RUN_LIMIT = 80,
  parameter  int unsigned WIN_LOG2  = 4,
  parameter  int unsigned RATIO     = 8,
  parameter  int unsigned PPM_W     = 20,
  localparam int unsigned RL_W      = $clog2(RUN_LIMIT + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rbit_i,
  input  logic             rbit_vld_i,
  input  logic             ref_tick_i,
  input  logic             los_i,
  input  logic [PPM_W-1:0] ppm_i,
  output logic             lock_o,
  output logic             ref_sel_o
);

  logic            run_bad;
  logic [RL_W-1:0] run_len;
  logic            win_done;
  logic            win_ok;
  logic            locked;

  lockdet_runlen #(.RUN_LIMIT(RUN_LIMIT)) u_runlen (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_i     (rbit_i),
    .bit_vld_i (rbit_vld_i),
    .run_bad_o (run_bad),
    .run_len_o (run_len)
  );

  lockdet_freq #(
    .WIN_LOG2 (WIN_LOG2),
    .RATIO    (RATIO),
    .PPM_W    (PPM_W)
  ) u_freq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_vld_i  (rbit_vld_i),
    .ref_tick_i (ref_tick_i),
    .ppm_i      (ppm_i),
    .done_o     (win_done),
    .ok_o       (win_ok)
  );

  lockdet_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_bad_i  (run_bad),
    .los_i      (los_i),
    .win_done_i (win_done),
    .win_ok_i   (win_ok),
    .locked_o   (locked)
  );

  assign lock_o    = locked;
  assign ref_sel_o = ~locked;

endmodule

// File: rtl/lockdet_chk.sv
module lockdet_chk #(
  parameter  int unsigned RUN_LIMIT = 80,
  localparam int unsigned RL_W      = $clog2(RUN_LIMIT + 2)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            los_i,
  input logic            lock_o,
  input logic            run_bad,
  input logic [RL_W-1:0] run_len,
  input logic            win_done,
  input logic            win_ok
);

  localparam logic [RL_W-1:0] CAP = RL_W'(RUN_LIMIT + 1);

  p_run_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run_bad |=> !lock_o);

  p_run_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= CAP);

  p_freq_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done && !win_ok) |=> !lock_o);

  p_relock_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(win_done && win_ok && !los_i && !run_bad));

  p_los_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    los_i |=> !lock_o);

endmodule

bind sdata_lock_detect lockdet_chk #(.RUN_LIMIT(RUN_LIMIT)) u_lockdet_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .los_i    (los_i),
  .lock_o   (lock_o),
  .run_bad  (run_bad),
  .run_len  (run_len),
  .win_done (win_done),
  .win_ok   (win_ok)
);

// File: tb/test_sdata_lock_detect.sv
`timescale 1ns/1ps
module test_sdata_lock_detect;

  localparam int PPM_W = 20;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             rbit_i;
  logic             rbit_vld_i;
  logic             ref_tick_i;
  logic             los_i;
  logic [PPM_W-1:0] ppm_i;
  logic             lock_o;
  logic             ref_sel_o;

  always #10 clk = ~clk; // 50 MHz

  sdata_lock_detect #(.RUN_LIMIT(80), .WIN_LOG2(4), .RATIO(8), .PPM_W(PPM_W)) i_sdata_lock_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .rbit_i     (rbit_i),
    .rbit_vld_i (rbit_vld_i),
    .ref_tick_i (ref_tick_i),
    .los_i      (los_i),
    .ppm_i      (ppm_i),
    .lock_o     (lock_o),
    .ref_sel_o  (ref_sel_o)
  );

  typedef struct {
    logic  exp_lock;
    string tag;
  } item_t;

  item_t sbq[$];
  int    n_run  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  // stimulus state applied at each falling edge
  logic cur   = 1'b0;
  logic vld_v = 1'b1;
  logic los_v = 1'b0;
  int   per   = 8;
  int   phase = 0;

  task automatic drive_cycle(input logic b);
    @(negedge clk);
    rbit_i     = b;
    rbit_vld_i = vld_v;
    los_i      = los_v;
    ref_tick_i = (phase == per - 1);
    phase      = (phase >= per - 1) ? 0 : phase + 1;
  endtask

  task automatic toggle(input int n);
    for (int i = 0; i < n; i++) begin
      cur = ~cur;
      drive_cycle(cur);
    end
  endtask

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) drive_cycle(cur);
  endtask

  // expectation applies to the outputs after the next rising edge
  task automatic expect_lock(input logic e, input string tag);
    item_t it;
    it.exp_lock = e;
    it.tag      = tag;
    sbq.push_back(it);
  endtask

  always @(posedge clk) begin
    item_t it;
    #5;
    if (sbq.size() != 0) begin
      it = sbq.pop_front();
      n_run++;
      if (lock_o !== it.exp_lock || ref_sel_o !== ~it.exp_lock) begin
        n_fail++;
        $display("FAIL %s: lock_o=%0b ref_sel_o=%0b expected %0b/%0b",
                 it.tag, lock_o, ref_sel_o, it.exp_lock, ~it.exp_lock);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rbit_i = 1'b0; rbit_vld_i = 1'b0; ref_tick_i = 1'b0;
    los_i = 1'b0; ppm_i = PPM_W'(100000);
    repeat (2) @(negedge clk);
    expect_lock(1'b0, "R6 reset state unlocked, reference selected");
    @(negedge clk);
    rst_n = 1'b1;
    phase = 0;

    toggle(400);
    expect_lock(1'b1, "R4 lock on clean nominal data");

    // R1: run exactly at the limit, then one beyond it
    toggle(1); hold(79); toggle(1);
    expect_lock(1'b1, "R1 run equal to limit keeps lock");
    toggle(1); hold(80); toggle(1);
    expect_lock(1'b0, "R1 run above limit drops lock next edge");
    toggle(400);
    expect_lock(1'b1, "R4 relock after run fault");

    // R2: long flat run keeps unlocked, transitions restart the count
    hold(600);
    expect_lock(1'b0, "R2 unbroken long run stays unlocked");
    toggle(400);
    expect_lock(1'b1, "R2 transitions restart run count");

    // R3: fast recovered clock (count 144 vs 128)
    per = 9; phase = 0;
    toggle(400);
    expect_lock(1'b0, "R3 fast by 16 beyond tolerance 12");
    ppm_i = PPM_W'(150000);
    toggle(400);
    expect_lock(1'b1, "R3 fast by 16 within tolerance 19");
    ppm_i = PPM_W'(125000);
    toggle(400);
    expect_lock(1'b1, "R3 deviation equal to tolerance 16 passes");
    ppm_i = PPM_W'(117188);
    toggle(400);
    expect_lock(1'b0, "R3 deviation 16 over tolerance 15 fails");

    // R3: slow recovered clock (count 112 vs 128)
    per = 7; phase = 0; ppm_i = PPM_W'(150000);
    toggle(400);
    expect_lock(1'b1, "R3 slow by 16 within tolerance 19");
    ppm_i = PPM_W'(100000);
    toggle(400);
    expect_lock(1'b0, "R3 slow by 16 beyond tolerance 12");
    per = 8; phase = 0;
    toggle(400);
    expect_lock(1'b1, "R4 relock at nominal frequency");

    // R5: loss of signal
    los_v = 1'b1;
    toggle(1);
    expect_lock(1'b0, "R5 los drops lock next edge");
    toggle(400);
    expect_lock(1'b0, "R5 no relock while los held");
    los_v = 1'b0;
    toggle(400);
    expect_lock(1'b1, "R5 relock after los clears");

    // R7: no valid bits in a window
    vld_v = 1'b0;
    toggle(400);
    expect_lock(1'b0, "R7 window without valid bits fails");
    vld_v = 1'b1;
    toggle(400);
    expect_lock(1'b1, "R7 relock once valid bits return");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule